// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block holds two independent hardware breakpoint channels for the debug logic of a 32-bit processor. Each clock cycle the processor presents at most one bus event. An event is an instruction fetch or an operand access, and it carries an address, an 8-bit address-space identifier, a direction, a size and a data value. Every channel compares that event against its own settings and raises a break request when all of its enabled conditions hold.

The settings arrive on plain input ports. They are address plus per-bit mask, identifier, event kind, direction, optional size, optional data with mask, and an optional down-counter of matches. On fetch events a channel can tag its break as pre-execution or post-execution. Operand breaks always carry the post-execution tag. The two channels share no state, so either one, both or neither can request a break on the same event.

Top module: `bp_match_pair`

## Requirements
- R1: An address-mask bit of 1 makes the corresponding address bit don't-care. With mask 0x00000FFE and address 0x8000, every even address from 0x8000 to 0x8FFE hits.
- R2: A hit needs the event identifier to equal the channel identifier exactly.
- R3: `cfg_fetch`=1 selects fetch events and 0 selects operand events. Fetch events ignore direction, size and data. `brk_post` follows `cfg_post` on a fetch break (1 = after execution).
- R4: An operand channel hits only when `ev_write` equals `cfg_write`. When `cfg_size_chk`=1 it also needs `ev_size`==`cfg_size`, where size codes are 0 byte, 1 halfword, 2 word.
- R5: An operand address is aligned to its size (low bit cleared for halfword, low two bits for word), and the event hits when the bytes it covers include the programmed address.
- R6: With `cfg_data_chk`=1, every data bit whose mask bit is 0 must equal the programmed data. Only the low 8 bits are compared for a byte access, the low 16 for a halfword, and all 32 for a word.
- R7: Each channel decides on its own, and both may break on the same event.
- R8: With `cfg_cnt_chk`=1, each full match decrements a counter that stops at 0. A break happens on a match while the counter is 0 or 1, so a loaded N≥1 breaks on the Nth match and a loaded 0 breaks on the first.
- R9: When `cnt_load` is high, the counter takes `cfg_cnt`, and a count-enabled channel does not break in that cycle.
- R10: `brk` is a registered pulse in the cycle after the event and lasts one cycle per event. Operand breaks have `brk_post`=1, and `brk_post` is never high without `brk`.
- R11: Synchronous reset clears both outputs and all counters.
- R12: No break happens when `ev_valid`=0 or when the channel's `cfg_en` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Bus event present |
| ev_fetch | input | 1 | 1 fetch, 0 operand access |
| ev_addr | input | 32 | Event address |
| ev_asid | input | 8 | Event address-space identifier |
| ev_write | input | 1 | 1 write, 0 read |
| ev_size | input | 2 | 0 byte, 1 halfword, 2 word |
| ev_data | input | 32 | Operand data |
| cfg_en | input | 2 | Per-channel enable |
| cfg_fetch | input | 2 | Per-channel event kind |
| cfg_post | input | 2 | Fetch break after execution |
| cfg_write | input | 2 | Operand direction |
| cfg_size_chk | input | 2 | Include size in match |
| cfg_data_chk | input | 2 | Include data in match |
| cfg_cnt_chk | input | 2 | Include match count |
| cnt_load | input | 2 | Load counter from cfg_cnt |
| cfg_addr | input | 64 | Address per channel |
| cfg_amask | input | 64 | Address don't-care mask per channel |
| cfg_asid | input | 16 | Identifier per channel |
| cfg_size | input | 4 | Size code per channel |
| cfg_data | input | 64 | Data per channel |
| cfg_dmask | input | 64 | Data don't-care mask per channel |
| cfg_cnt | input | 64 | Count load value per channel |
| brk | output | 2 | Break request pulse per channel |
| brk_post | output | 2 | Break tagged post-execution |

## Verification
Two things can happen in the same cycle: a counter reload and a full match on the same channel. The bench provokes this by raising `cnt_load` together with a matching event. It then expects no break in that cycle, and it expects the following matches to count from the newly loaded value. In a second case, the same event hits both channels, and the bench expects two simultaneous pulses with their own tags.

// File: rtl/bp_match_pair.sv
module bp_match_pair #(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IDW = 8,
  parameter int CW  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_valid,
  input  logic                ev_fetch,
  input  logic [AW-1:0]       ev_addr,
  input  logic [IDW-1:0]      ev_asid,
  input  logic                ev_write,
  input  logic [1:0]          ev_size,
  input  logic [DW-1:0]       ev_data,
  input  logic [NCH-1:0]      cfg_en,
  input  logic [NCH-1:0]      cfg_fetch,
  input  logic [NCH-1:0]      cfg_post,
  input  logic [NCH-1:0]      cfg_write,
  input  logic [NCH-1:0]      cfg_size_chk,
  input  logic [NCH-1:0]      cfg_data_chk,
  input  logic [NCH-1:0]      cfg_cnt_chk,
  input  logic [NCH-1:0]      cnt_load,
  input  logic [NCH*AW-1:0]   cfg_addr,
  input  logic [NCH*AW-1:0]   cfg_amask,
  input  logic [NCH*IDW-1:0]  cfg_asid,
  input  logic [NCH*2-1:0]    cfg_size,
  input  logic [NCH*DW-1:0]   cfg_data,
  input  logic [NCH*DW-1:0]   cfg_dmask,
  input  logic [NCH*CW-1:0]   cfg_cnt,
  output logic [NCH-1:0]      brk,
  output logic [NCH-1:0]      brk_post
);

  logic [AW-1:0] lo_clr;
  logic [DW-1:0] lane;

  always_comb begin
    lo_clr = '0;
    lane   = '1;
    case (ev_size)
      2'd0: begin lo_clr = '0;       lane = DW'(8'hFF);    end
      2'd1: begin lo_clr = AW'(1);   lane = DW'(16'hFFFF); end
      default: begin lo_clr = AW'(3); lane = '1;           end
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire [AW-1:0]  c_addr  = cfg_addr[i*AW +: AW];
    wire [AW-1:0]  c_amask = cfg_amask[i*AW +: AW];
    wire [IDW-1:0] c_asid  = cfg_asid[i*IDW +: IDW];
    wire [1:0]     c_size  = cfg_size[i*2 +: 2];
    wire [DW-1:0]  c_data  = cfg_data[i*DW +: DW];
    wire [DW-1:0]  c_dmask = cfg_dmask[i*DW +: DW];
    wire [CW-1:0]  c_cnt   = cfg_cnt[i*CW +: CW];

    wire [AW-1:0] care     = ~c_amask & ~(ev_fetch ? '0 : lo_clr);
    wire          addr_hit = ((ev_addr ^ c_addr) & care) == '0;
    wire          asid_hit = ev_asid == c_asid;
    wire          kind_hit = ev_fetch ? cfg_fetch[i]
                           : (!cfg_fetch[i] && ev_write == cfg_write[i]
                              && (!cfg_size_chk[i] || ev_size == c_size));
    wire          data_hit = ev_fetch || !cfg_data_chk[i]
                           || (((ev_data ^ c_data) & ~c_dmask & lane) == '0);
    wire          hit      = ev_valid && cfg_en[i] && addr_hit && asid_hit
                             && kind_hit && data_hit;

    logic [CW-1:0] cnt;
    logic          brk_q, post_q;
    wire           cnt_ok = !cfg_cnt_chk[i] || (!cnt_load[i] && cnt <= CW'(1));
    wire           fire   = hit && cnt_ok;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt    <= '0;
        brk_q  <= 1'b0;
        post_q <= 1'b0;
      end else begin
        brk_q  <= fire;
        post_q <= fire && (!ev_fetch || cfg_post[i]);
        if (cnt_load[i])
          cnt <= c_cnt;
        else if (hit && cfg_cnt_chk[i] && cnt != '0)
          cnt <= cnt - CW'(1);
      end
    end

    assign brk[i]      = brk_q;
    assign brk_post[i] = post_q;
  end

endmodule

module bp_match_pair_chk #(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IDW = 8,
  parameter int CW  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               ev_valid,
  input logic               ev_fetch,
  input logic [IDW-1:0]     ev_asid,
  input logic               ev_write,
  input logic [NCH-1:0]     cfg_en,
  input logic [NCH-1:0]     cfg_fetch,
  input logic [NCH-1:0]     cfg_write,
  input logic [NCH-1:0]     cfg_cnt_chk,
  input logic [NCH-1:0]     cnt_load,
  input logic [NCH*IDW-1:0] cfg_asid,
  input logic [NCH-1:0]     brk,
  input logic [NCH-1:0]     brk_post
);

  assert_reset_clears_R11: assert property (@(posedge clk) rst |=> (brk == '0 && brk_post == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_asid_equal_R2: assert property (@(posedge clk) disable iff (rst)
      brk[i] |-> $past(ev_asid) == $past(cfg_asid[i*IDW +: IDW]));
    assert_kind_R3: assert property (@(posedge clk) disable iff (rst)
      brk[i] |-> $past(ev_fetch) == $past(cfg_fetch[i]));
    assert_direction_R4: assert property (@(posedge clk) disable iff (rst)
      (brk[i] && !$past(ev_fetch)) |-> $past(ev_write) == $past(cfg_write[i]));
    assert_load_blocks_R9: assert property (@(posedge clk) disable iff (rst)
      $past(cnt_load[i] && cfg_cnt_chk[i]) |-> !brk[i]);
    assert_tag_needs_break_R10: assert property (@(posedge clk) disable iff (rst)
      brk_post[i] |-> brk[i]);
    assert_gated_R12: assert property (@(posedge clk) disable iff (rst)
      brk[i] |-> $past(ev_valid && cfg_en[i]));
  end

endmodule

bind bp_match_pair bp_match_pair_chk #(.NCH(NCH), .AW(AW), .DW(DW), .IDW(IDW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_fetch(ev_fetch), .ev_asid(ev_asid),
  .ev_write(ev_write), .cfg_en(cfg_en), .cfg_fetch(cfg_fetch), .cfg_write(cfg_write),
  .cfg_cnt_chk(cfg_cnt_chk), .cnt_load(cnt_load), .cfg_asid(cfg_asid),
  .brk(brk), .brk_post(brk_post));

// File: tb/test_bp_match_pair.sv
module test_bp_match_pair;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst, ev_valid, ev_fetch, ev_write;
  logic [31:0] ev_addr, ev_data;
  logic [7:0]  ev_asid;
  logic [1:0]  ev_size;
  logic [1:0]  cfg_en, cfg_fetch, cfg_post, cfg_write, cfg_size_chk, cfg_data_chk, cfg_cnt_chk, cnt_load;
  logic [63:0] cfg_addr, cfg_amask, cfg_data, cfg_dmask, cfg_cnt;
  logic [15:0] cfg_asid;
  logic [3:0]  cfg_size;
  logic [1:0]  brk, brk_post;

  bp_match_pair i_bp_match_pair (.*);

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic ev(input logic f, input logic [31:0] a, input logic [7:0] id,
                    input logic w, input logic [1:0] sz, input logic [31:0] d);
    ev_valid = 1; ev_fetch = f; ev_addr = a; ev_asid = id; ev_write = w; ev_size = sz; ev_data = d;
    @(posedge clk); #1;
    ev_valid = 0; cnt_load = 0;
  endtask

  task automatic idle();
    ev_valid = 0;
    @(posedge clk); #1;
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst = 1; ev_valid = 0; ev_fetch = 0; ev_write = 0; ev_addr = 0; ev_data = 0; ev_asid = 0; ev_size = 0;
    cfg_en = 0; cfg_fetch = 0; cfg_post = 0; cfg_write = 0; cfg_size_chk = 0; cfg_data_chk = 0;
    cfg_cnt_chk = 0; cnt_load = 0; cfg_addr = 0; cfg_amask = 0; cfg_data = 0; cfg_dmask = 0;
    cfg_cnt = 0; cfg_asid = 0; cfg_size = 0;
    @(posedge clk); #1;
    // R11: matching event under reset gives nothing
    cfg_en = 2'b11; cfg_fetch = 2'b11;
    rst = 1;
    ev(1, 0, 0, 0, 2, 0);
    chk("R11 reset brk", brk, 0);
    chk("R11 reset post", brk_post, 0);
    rst = 0;

    // Fetch sweep: R1 R2 R3
    cfg_addr[31:0] = 32'h8010; cfg_amask[31:0] = 32'h6; cfg_asid[7:0] = 8'h70; cfg_post[0] = 0;
    cfg_addr[63:32] = 32'h8000; cfg_amask[63:32] = 32'hFFE; cfg_asid[15:8] = 8'h80; cfg_post[1] = 1;
    for (int k = 0; k < 2; k++) begin
      for (int a = 32'h7FF0; a <= 32'h9010; a += 2) begin
        logic [7:0] id;
        logic e0, e1;
        id = (k == 0) ? 8'h70 : 8'h80;
        e0 = (id == 8'h70) && a >= 32'h8010 && a <= 32'h8016;
        e1 = (id == 8'h80) && a >= 32'h8000 && a <= 32'h8FFE;
        ev(1, a, id, a[2], 2'(a % 3), 32'hDEAD);
        chk("R1 R2 fetch ch0", brk[0], e0);
        chk("R1 R2 fetch ch1", brk[1], e1);
        chk("R3 fetch tag", brk_post, {e1, 1'b0});
      end
    end
    // R1: odd address with bit0 cared misses
    ev(1, 32'h8011, 8'h80, 0, 2, 0);
    chk("R1 odd address", brk[1], 0);
    // R3: fetch channel ignores operand events
    ev(0, 32'h8010, 8'h70, 0, 2, 0);
    chk("R3 operand vs fetch channel", brk, 0);

    // Operand sweep: R4 R5 R6 R10
    cfg_fetch = 2'b00;
    cfg_addr[31:0] = 32'h123456; cfg_amask[31:0] = 0; cfg_asid[7:0] = 8'h80; cfg_write[0] = 0;
    cfg_size_chk[0] = 0; cfg_data_chk[0] = 0;
    cfg_addr[63:32] = 32'h123400; cfg_amask[63:32] = 32'hFF; cfg_asid[15:8] = 8'h80; cfg_write[1] = 1;
    cfg_size_chk[1] = 1; cfg_size[3:2] = 2'd1; cfg_data_chk[1] = 1; cfg_data[63:32] = 32'h0000A512;
    cfg_dmask[63:32] = 0;
    for (int a = 32'h123440; a <= 32'h12345F; a++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int w = 0; w < 2; w++) begin
          for (int dv = 0; dv < 3; dv++) begin
            logic [31:0] d, al;
            int nb;
            logic e0, e1;
            d = (dv == 0) ? 32'hFFFFA512 : (dv == 1) ? 32'h0000A513 : 32'h00000012;
            nb = 1 << sz;
            al = a - (a % nb);
            e0 = (w == 0) && 32'h123456 >= al && 32'h123456 < al + nb;
            e1 = (w == 1) && (sz == 1) && (d[15:0] == 16'hA512);
            ev(0, a, 8'h80, w[0], sz[1:0], d);
            chk("R5 R4 cover ch0", brk[0], e0);
            chk("R4 R6 size data ch1", brk[1], e1);
            chk("R10 operand tag", brk_post, {e1, e0});
          end
        end
      end
    end
    // R10: pulse is single
    ev(0, 32'h123456, 8'h80, 0, 0, 0);
    chk("R10 hit", brk[0], 1);
    idle();
    chk("R10 pulse ends", brk, 0);
    // R2: wrong identifier
    ev(0, 32'h123456, 8'h70, 0, 0, 0);
    chk("R2 other asid", brk[0], 0);

    // R6 data mask and byte lane
    cfg_dmask[63:32] = 32'hFF;
    ev(0, 32'h123402, 8'h80, 1, 1, 32'h0000A5FF);
    chk("R6 masked low byte", brk[1], 1);
    ev(0, 32'h123402, 8'h80, 1, 1, 32'h0000A412);
    chk("R6 unmasked bit", brk[1], 0);
    cfg_write[0] = 1; cfg_data_chk[0] = 1; cfg_data[31:0] = 32'h3C; cfg_dmask[31:0] = 0;
    ev(0, 32'h123456, 8'h80, 1, 0, 32'hABCDEF3C);
    chk("R6 byte lane hit", brk[0], 1);
    ev(0, 32'h123456, 8'h80, 1, 0, 32'h0000003D);
    chk("R6 byte lane miss", brk[0], 0);

    // R7 independence and R12 gating
    cfg_fetch = 2'b11; cfg_post = 2'b10; cfg_amask = 0;
    cfg_addr = {32'h4000, 32'h4000}; cfg_asid = {8'h11, 8'h11};
    ev(1, 32'h4000, 8'h11, 0, 2, 0);
    chk("R7 both fire", brk, 2'b11);
    chk("R7 own tags", brk_post, 2'b10);
    cfg_en = 2'b01;
    ev(1, 32'h4000, 8'h11, 0, 2, 0);
    chk("R12 disabled channel", brk, 2'b01);
    cfg_en = 2'b11;
    ev_fetch = 1; ev_addr = 32'h4000; ev_asid = 8'h11;
    idle();
    chk("R12 invalid event", brk, 0);

    // R8 count, R9 load collision
    cfg_cnt_chk = 2'b01; cfg_cnt[31:0] = 3; cnt_load = 2'b01;
    idle(); cnt_load = 0;
    for (int n = 1; n <= 4; n++) begin
      ev(1, 32'h4000, 8'h11, 0, 2, 0);
      chk("R8 count 3", brk[0], n >= 3);
      chk("R7 uncounted channel", brk[1], 1);
    end
    cfg_cnt[31:0] = 0; cnt_load = 2'b01;
    idle(); cnt_load = 0;
    ev(1, 32'h4000, 8'h11, 0, 2, 0);
    chk("R8 count 0 first match", brk[0], 1);
    cfg_cnt[31:0] = 2; cnt_load = 2'b01;
    ev(1, 32'h4000, 8'h11, 0, 2, 0);
    chk("R9 load cycle blocks", brk[0], 0);
    ev(1, 32'h4000, 8'h11, 0, 2, 0);
    chk("R9 first after load", brk[0], 0);
    ev(1, 32'h4000, 8'h11, 0, 2, 0);
    chk("R9 second after load", brk[0], 1);
    // R11 reset clears counter
    cfg_cnt[31:0] = 5; cnt_load = 2'b01;
    idle(); cnt_load = 0;
    rst = 1; idle(); rst = 0;
    ev(1, 32'h4000, 8'h11, 0, 2, 0);
    chk("R11 counter cleared", brk[0], 1);

    finish_up();
  end
endmodule